// File: doc/BRIEF.md
# Banked Prioritised Interrupt Controller

This block is a first-level interrupt controller for a processor core. Its request sources are grouped into banks of 32. Each source has a mask bit and a small configuration word that sets three things: whether the source is routed to the fast-interrupt output, whether it is captured on a rising edge or followed as a level, and a 5-bit priority. Two arbiters run side by side, one for fast-interrupt sources and one for normal sources. Each arbiter picks the most urgent eligible request, latches its number, raises its output and holds that choice until software acknowledges it.

Software reaches the block through a simple write strobe with a combinational read port. Source `n` is in bank `n >> 5` at bit `n & 31`, and the bank is selected by address bits 11:8. A second-level controller is attached by wiring its request to an ordinary source input and unmasking that source. A software-trigger register lets firmware raise any source, and a global mask silences both outputs.

Top module: `prio_intc`

## Requirements
- R1: After reset every mask bit reads 1, the trigger register and every configuration word read 0, the global mask reads 0, and both outputs and both latched-source registers read low (valid bit clear).
- R2: Source n sits in bank n>>5 at bit n&31, and the bank is chosen by address bits 11:8. In the mask word (offset 0x04) a 1 blocks the source and a 0 lets it request. A masked source never reaches an output.
- R3: The configuration word of bit b is at offset 0x80+4*b. Bit 0 routes to the fast output, bit 1 selects edge capture (1) or level (0), and bits 6:2 hold the priority. In banks other than 0 the routing bit is stored and read as 0, and the source goes to the normal output.
- R4: Among eligible requests of one output, the lowest priority value wins. On equal values, the lower source number wins.
- R5: Sources routed to the fast output are arbitrated apart from the rest and drive only fiqOut. All others drive only irqOut.
- R6: The latched winner reads at offset 0x0C (normal) or 0x10 (fast) as bit 31 = valid and the low bits = source number. It does not change while its output is held, even when a more urgent request arrives.
- R7: Writing the control word (offset 0x08) with bit 0 set acknowledges the normal output, and with bit 1 set acknowledges the fast output. The acknowledged output is low in the following cycle, and a new winner is latched one clock edge later. The other output is unaffected.
- R8: An edge source sets a pending flag on a rising input edge. The flag is cleared only when that source is acknowledged, so an input that stays high does not request again. A level source requests for as long as its input is high, and it fires again after an acknowledge.
- R9: A 1 in the software-trigger word (offset 0x18) makes that source request exactly as a high input would. The word reads back as written.
- R10: While the global mask (offset 0x14, bit 0) is 1, both outputs are low and no new winner is latched. Clearing the mask lets the arbitration resume.
- R11: The output rises on the first clock edge after a level request becomes eligible, and on the second clock edge after the input rises for an edge source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address: bank in 11:8, offset in 7:0 |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| srcIn | input | NUM_BANKS*32 | Interrupt request inputs, one per source |
| irqOut | output | 1 | Normal interrupt request to the core |
| fiqOut | output | 1 | Fast interrupt request to the core |

## Verification
The properties assume that register writes arrive as single-cycle strobes with a stable address, and that the acknowledge and global-mask writes are issued to bank 0 at their documented offsets. The bench drives every input on the falling clock edge and holds each write for exactly one rising edge. It resets the block before each scenario, so no scenario inherits pending edges or latched winners from an earlier one. Each priority change and each unmask happens while its output is idle or latched, which keeps the expected winner free of ambiguity.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int BANK_SRCS = 32;
  localparam int PRIO_W    = 5;

  localparam logic [7:0] OFF_PEND   = 8'h00;
  localparam logic [7:0] OFF_MASK   = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_IRQSRC = 8'h0C;
  localparam logic [7:0] OFF_FIQSRC = 8'h10;
  localparam logic [7:0] OFF_GMASK  = 8'h14;
  localparam logic [7:0] OFF_TRIG   = 8'h18;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              edgeMode;
    logic              fiqSel;
  } lvlCfg_t;

  typedef struct packed {
    logic maskWr;
    logic trigWr;
    logic lvlWr;
    logic gmaskWr;
    logic latchIrq;
    logic latchFiq;
    logic clrIrq;
    logic clrFiq;
  } strobe_t;
endpackage

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
  parameter int N      = 64,
  parameter int SRC_W  = 6,
  parameter int PRIO_W = 5
) (
  input  logic [N-1:0]        req,
  input  logic [N*PRIO_W-1:0] prioFlat,
  output logic                winValid,
  output logic [SRC_W-1:0]    winId
);
  logic [PRIO_W-1:0] bestPrio;

  // Strict less-than keeps the earlier (lower) index on a tie.
  always_comb begin
    winValid = 1'b0;
    winId    = '0;
    bestPrio = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!winValid || prioFlat[i*PRIO_W +: PRIO_W] < bestPrio)) begin
        winValid = 1'b1;
        winId    = SRC_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [11:0] regAddr,
  input  logic [1:0]  ctrlBits,
  input  logic        irqCand,
  input  logic        fiqCand,
  input  logic        gmaskQ,
  output strobe_t     stb,
  output logic        irqBusy,
  output logic        fiqBusy,
  output logic        irqOut,
  output logic        fiqOut
);
  logic [3:0] bankSel;
  logic [7:0] offSel;
  logic       wrOk;
  logic       ackIrq;
  logic       ackFiq;

  assign bankSel = regAddr[11:8];
  assign offSel  = regAddr[7:0];
  assign wrOk    = regWr && (int'(bankSel) < NUM_BANKS);
  assign ackIrq  = wrOk && (offSel == OFF_CTRL) && ctrlBits[0];
  assign ackFiq  = wrOk && (offSel == OFF_CTRL) && ctrlBits[1];

  always_comb begin
    stb          = '0;
    stb.maskWr   = wrOk && (offSel == OFF_MASK);
    stb.trigWr   = wrOk && (offSel == OFF_TRIG);
    stb.gmaskWr  = wrOk && (offSel == OFF_GMASK);
    stb.lvlWr    = wrOk && offSel[7] && (offSel[1:0] == 2'b00);
    stb.clrIrq   = ackIrq && irqBusy;
    stb.clrFiq   = ackFiq && fiqBusy;
    stb.latchIrq = !irqBusy && irqCand && !gmaskQ;
    stb.latchFiq = !fiqBusy && fiqCand && !gmaskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqBusy <= 1'b0;
      fiqBusy <= 1'b0;
    end else begin
      if (stb.clrIrq)        irqBusy <= 1'b0;
      else if (stb.latchIrq) irqBusy <= 1'b1;
      if (stb.clrFiq)        fiqBusy <= 1'b0;
      else if (stb.latchFiq) fiqBusy <= 1'b1;
    end
  end

  assign irqOut = irqBusy && !gmaskQ;
  assign fiqOut = fiqBusy && !gmaskQ;
endmodule

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int SRC_N     = NUM_BANKS * BANK_SRCS,
  parameter int SRC_W     = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [11:0]      regAddr,
  input  logic [31:0]      regWdata,
  input  logic [SRC_N-1:0] srcIn,
  input  logic             irqBusy,
  input  logic             fiqBusy,
  output logic [31:0]      regRdata,
  output logic             irqCand,
  output logic             fiqCand,
  output logic             gmaskQ,
  output logic [SRC_W-1:0] irqSrcQ,
  output logic [SRC_W-1:0] fiqSrcQ
);
  logic [3:0]       bankSel;
  logic [4:0]       bitSel;
  logic [7:0]       offSel;
  logic             bankOk;
  logic [SRC_W-1:0] cfgIdx;

  assign bankSel = regAddr[11:8];
  assign bitSel  = regAddr[6:2];
  assign offSel  = regAddr[7:0];
  assign bankOk  = int'(bankSel) < NUM_BANKS;
  assign cfgIdx  = SRC_W'({bankSel, bitSel});

  logic [SRC_N-1:0] maskQ, trigQ, prevQ, edgePendQ;
  lvlCfg_t          lvlQ [SRC_N];

  logic [SRC_N-1:0]        rawReq, reqNow, elig, fiqV, edgeV, clrHit;
  logic [SRC_N*PRIO_W-1:0] prioFlat;
  logic [SRC_W-1:0]        irqWin, fiqWin;

  assign rawReq = srcIn | trigQ;
  assign elig   = reqNow & ~maskQ;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    assign prioFlat[i*PRIO_W +: PRIO_W] = lvlQ[i].prio;
    assign fiqV[i]   = lvlQ[i].fiqSel;
    assign edgeV[i]  = lvlQ[i].edgeMode;
    assign reqNow[i] = edgeV[i] ? edgePendQ[i] : rawReq[i];
    assign clrHit[i] = (stb.clrIrq && irqSrcQ == SRC_W'(i)) ||
                       (stb.clrFiq && fiqSrcQ == SRC_W'(i));
  end

  prio_intc_arb #(.N(SRC_N), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_arbIrq (
    .req(elig & ~fiqV), .prioFlat(prioFlat), .winValid(irqCand), .winId(irqWin));

  prio_intc_arb #(.N(SRC_N), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_arbFiq (
    .req(elig & fiqV), .prioFlat(prioFlat), .winValid(fiqCand), .winId(fiqWin));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ     <= '1;
      trigQ     <= '0;
      gmaskQ    <= 1'b0;
      prevQ     <= '0;
      edgePendQ <= '0;
      irqSrcQ   <= '0;
      fiqSrcQ   <= '0;
      for (int i = 0; i < SRC_N; i++) lvlQ[i] <= '0;
    end else begin
      if (stb.maskWr)  maskQ[int'(bankSel)*BANK_SRCS +: BANK_SRCS] <= regWdata;
      if (stb.trigWr)  trigQ[int'(bankSel)*BANK_SRCS +: BANK_SRCS] <= regWdata;
      if (stb.gmaskWr) gmaskQ <= regWdata[0];
      if (stb.lvlWr) begin
        lvlQ[cfgIdx].prio     <= regWdata[6:2];
        lvlQ[cfgIdx].edgeMode <= regWdata[1];
        lvlQ[cfgIdx].fiqSel   <= (bankSel == 4'd0) && regWdata[0];
      end
      prevQ <= rawReq;
      for (int i = 0; i < SRC_N; i++) begin
        if (edgeV[i] && rawReq[i] && !prevQ[i]) edgePendQ[i] <= 1'b1;
        else if (clrHit[i])                     edgePendQ[i] <= 1'b0;
      end
      if (stb.latchIrq) irqSrcQ <= irqWin;
      if (stb.latchFiq) fiqSrcQ <= fiqWin;
    end
  end

  always_comb begin
    regRdata = '0;
    if (bankOk) begin
      if (offSel[7]) begin
        regRdata = {25'd0, lvlQ[cfgIdx]};
      end else begin
        case (offSel)
          OFF_PEND:   regRdata = reqNow[int'(bankSel)*BANK_SRCS +: BANK_SRCS];
          OFF_MASK:   regRdata = maskQ[int'(bankSel)*BANK_SRCS +: BANK_SRCS];
          OFF_TRIG:   regRdata = trigQ[int'(bankSel)*BANK_SRCS +: BANK_SRCS];
          OFF_IRQSRC: regRdata = {irqBusy, {(31-SRC_W){1'b0}}, irqSrcQ};
          OFF_FIQSRC: regRdata = {fiqBusy, {(31-SRC_W){1'b0}}, fiqSrcQ};
          OFF_GMASK:  regRdata = {31'd0, gmaskQ};
          default:    regRdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int SRC_N    = NUM_BANKS * 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [11:0]      regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [SRC_N-1:0] srcIn,
  output logic             irqOut,
  output logic             fiqOut
);
  localparam int SRC_W = $clog2(SRC_N);

  strobe_t          stb;
  logic             irqCand, fiqCand, gmaskQ, irqBusy, fiqBusy;
  logic [SRC_W-1:0] irqSrcQ, fiqSrcQ;

  prio_intc_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .ctrlBits(regWdata[1:0]), .irqCand(irqCand), .fiqCand(fiqCand),
    .gmaskQ(gmaskQ), .stb(stb), .irqBusy(irqBusy), .fiqBusy(fiqBusy),
    .irqOut(irqOut), .fiqOut(fiqOut));

  prio_intc_dp #(.NUM_BANKS(NUM_BANKS), .SRC_N(SRC_N), .SRC_W(SRC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .regWdata(regWdata),
    .srcIn(srcIn), .irqBusy(irqBusy), .fiqBusy(fiqBusy), .regRdata(regRdata),
    .irqCand(irqCand), .fiqCand(fiqCand), .gmaskQ(gmaskQ),
    .irqSrcQ(irqSrcQ), .fiqSrcQ(fiqSrcQ));
endmodule

// File: rtl/prio_intc_sva.sv
module prio_intc_sva #(
  parameter int SRC_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic [11:0]      regAddr,
  input logic [1:0]       wBits,
  input logic             irqOut,
  input logic             fiqOut,
  input logic [SRC_W-1:0] irqSrcQ,
  input logic [SRC_W-1:0] fiqSrcQ
);
  // R10: setting the global mask silences both outputs on the next cycle
  assert_gmask_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 12'h014 && wBits[0]) |=> (!irqOut && !fiqOut));

  // R7: acknowledging the normal output drops it next cycle
  assert_ack_irq_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 12'h008 && wBits[0] && irqOut) |=> !irqOut);

  // R7: acknowledging the fast output drops it next cycle
  assert_ack_fiq_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == 12'h008 && wBits[1] && fiqOut) |=> !fiqOut);

  // R6: the latched winner holds while its output stays high
  assert_src_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && $past(irqOut)) |-> $stable(irqSrcQ));

  // R3: only bank 0 sources can reach the fast output
  assert_fiq_bank0_R3: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (int'(fiqSrcQ) < 32));
endmodule

bind prio_intc prio_intc_sva #(.SRC_W(SRC_W)) u_sva (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .wBits(regWdata[1:0]), .irqOut(irqOut), .fiqOut(fiqOut),
  .irqSrcQ(irqSrcQ), .fiqSrcQ(fiqSrcQ));

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int NB = 2;
  localparam int SN = NB * 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWr = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [SN-1:0] srcIn = '0;
  logic          irqOut, fiqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  prio_intc #(.NUM_BANKS(NB)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .srcIn(srcIn),
    .irqOut(irqOut), .fiqOut(fiqOut));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  function automatic logic [11:0] cfgAddr(input int src);
    return 12'((src / 32) << 8) | 12'h080 | 12'((src % 32) << 2);
  endfunction

  function automatic logic [31:0] cfgVal(input bit fiq, input bit edg, input int prio);
    return {25'd0, 5'(prio), edg, fiq};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; srcIn = '0; regWr = 1'b0;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    doReset();
    rd(12'h004, v); chk("R1 mask bank0", v, 32'hFFFF_FFFF);
    rd(12'h104, v); chk("R1 mask bank1", v, 32'hFFFF_FFFF);
    rd(12'h018, v); chk("R1 trig", v, 32'h0);
    rd(cfgAddr(7), v); chk("R1 cfg src7", v, 32'h0);
    rd(12'h014, v); chk("R1 gmask", v, 32'h0);
    rd(12'h00C, v); chk("R1 irq src reg", v, 32'h0);
    chk("R1 irqOut", {31'd0, irqOut}, 32'd0);
    chk("R1 fiqOut", {31'd0, fiqOut}, 32'd0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    doReset();
    wr(cfgAddr(3), cfgVal(0, 0, 4));
    srcIn[3] = 1'b1;
    cyc(3);
    chk("R2 masked source silent", {31'd0, irqOut}, 32'd0);
    wr(12'h004, ~(32'd1 << 3));
    chk("R11 level not before edge", {31'd0, irqOut}, 32'd0);
    cyc(1);
    chk("R11 level one edge", {31'd0, irqOut}, 32'd1);
    rd(12'h00C, v); chk("R6 irq src reg", v, 32'h8000_0003);
    wr(12'h008, 32'h1);
    chk("R7 ack drops irq", {31'd0, irqOut}, 32'd0);
    cyc(1);
    chk("R8 level refires", {31'd0, irqOut}, 32'd1);
    srcIn[3] = 1'b0;
    wr(12'h008, 32'h1);
    cyc(2);
    chk("R8 level released", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    doReset();
    wr(cfgAddr(5), cfgVal(0, 1, 0));
    wr(12'h004, ~(32'd1 << 5));
    srcIn[5] = 1'b1;
    cyc(1);
    chk("R11 edge not at first edge", {31'd0, irqOut}, 32'd0);
    cyc(1);
    chk("R11 edge at second edge", {31'd0, irqOut}, 32'd1);
    wr(12'h008, 32'h1);
    cyc(3);
    chk("R8 edge no refire while high", {31'd0, irqOut}, 32'd0);
    rd(12'h000, v); chk("R8 edge pending cleared", v & (32'd1 << 5), 32'd0);
    srcIn[5] = 1'b0;
    cyc(1);
    srcIn[5] = 1'b1;
    cyc(2);
    chk("R8 new edge fires", {31'd0, irqOut}, 32'd1);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    doReset();
    wr(cfgAddr(3),  cfgVal(0, 0, 5));
    wr(cfgAddr(10), cfgVal(0, 0, 2));
    wr(cfgAddr(12), cfgVal(0, 0, 2));
    wr(cfgAddr(40), cfgVal(0, 0, 1));
    srcIn[3] = 1'b1; srcIn[10] = 1'b1; srcIn[12] = 1'b1; srcIn[40] = 1'b1;
    wr(12'h004, ~((32'd1 << 3) | (32'd1 << 10) | (32'd1 << 12)));
    cyc(1);
    rd(12'h00C, v); chk("R4 tie lower number", v, 32'h8000_000A);
    srcIn[10] = 1'b0;
    wr(12'h008, 32'h1);
    cyc(1);
    rd(12'h00C, v); chk("R4 next equal priority", v, 32'h8000_000C);
    srcIn[12] = 1'b0;
    wr(12'h008, 32'h1);
    cyc(1);
    rd(12'h00C, v); chk("R4 lowest remaining", v, 32'h8000_0003);
    wr(12'h104, ~(32'd1 << 8));
    wr(12'h008, 32'h1);
    cyc(1);
    rd(12'h00C, v); chk("R2 bank1 bit8 is source 40", v, 32'h8000_0028);
  endtask

  task automatic t_fiq();
    logic [31:0] v;
    doReset();
    wr(cfgAddr(4), cfgVal(1, 0, 3));
    wr(cfgAddr(40), cfgVal(1, 0, 0));
    rd(cfgAddr(40), v); chk("R3 fiq bit dropped in bank1", v, 32'h0);
    rd(cfgAddr(4), v);  chk("R3 cfg readback bank0", v, 32'h0000_000D);
    wr(12'h004, ~(32'd1 << 4));
    wr(12'h104, ~(32'd1 << 8));
    srcIn[4] = 1'b1; srcIn[40] = 1'b1;
    cyc(2);
    chk("R5 fiqOut", {31'd0, fiqOut}, 32'd1);
    chk("R5 irqOut", {31'd0, irqOut}, 32'd1);
    rd(12'h010, v); chk("R5 fiq src", v, 32'h8000_0004);
    rd(12'h00C, v); chk("R3 bank1 routed normal", v, 32'h8000_0028);
    srcIn[4] = 1'b0;
    wr(12'h008, 32'h2);
    chk("R7 fiq ack drops fiq", {31'd0, fiqOut}, 32'd0);
    chk("R7 fiq ack keeps irq", {31'd0, irqOut}, 32'd1);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    doReset();
    wr(cfgAddr(9), cfgVal(0, 0, 7));
    wr(cfgAddr(2), cfgVal(0, 0, 0));
    wr(12'h004, ~((32'd1 << 9) | (32'd1 << 2)));
    srcIn[9] = 1'b1;
    cyc(2);
    srcIn[2] = 1'b1;
    cyc(3);
    rd(12'h00C, v); chk("R6 winner held", v, 32'h8000_0009);
    wr(12'h008, 32'h1);
    cyc(1);
    rd(12'h00C, v); chk("R6 new winner after ack", v, 32'h8000_0002);
  endtask

  task automatic t_gmask();
    logic [31:0] v;
    doReset();
    wr(12'h014, 32'h1);
    wr(12'h004, ~(32'd1 << 6));
    srcIn[6] = 1'b1;
    cyc(3);
    chk("R10 gated output", {31'd0, irqOut}, 32'd0);
    rd(12'h00C, v); chk("R10 no latch while masked", v, 32'h0);
    wr(12'h014, 32'h0);
    cyc(1);
    chk("R10 resumes", {31'd0, irqOut}, 32'd1);
    wr(12'h014, 32'h1);
    chk("R10 gates held output", {31'd0, irqOut}, 32'd0);
  endtask

  task automatic t_trig();
    logic [31:0] v;
    doReset();
    wr(12'h004, ~(32'd1 << 15));
    wr(12'h018, 32'd1 << 15);
    rd(12'h018, v); chk("R9 trig readback", v, 32'd1 << 15);
    cyc(1);
    chk("R9 software request", {31'd0, irqOut}, 32'd1);
    rd(12'h00C, v); chk("R9 trig source", v, 32'h8000_000F);
    wr(12'h018, 32'h0);
    wr(12'h008, 32'h1);
    cyc(2);
    chk("R9 trig cleared", {31'd0, irqOut}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_prio();
    t_fiq();
    t_hold();
    t_gmask();
    t_trig();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule